// File: doc/BRIEF.md
# Horizontal Correction Point Sequencer

This block paces the output of shading correction values across one video line. It watches the horizontal sync input for its active edge, with the active polarity chosen by a control bit. It then waits a programmed number of master clocks before it walks through a programmed window of horizontal correction points, either ascending or descending. Each point index is held for a programmed number of master clocks. The current index goes out to the neighbouring interpolator, which returns the 6-bit value for that point. The block registers that value as the code for the DAC, and it emits a one-clock DAC strobe whose delay after each new code is selectable.

A fixed idle code replaces the point values when correction is switched off, while a configuration transfer is in progress, or in standby. In standby the sequencer freezes and the output enable drops, so the pads around the block can float. A pin selects whether the master clock is the input clock or half of it. Half rate is made with a clock enable, so no second clock domain exists.

Top module: `hcp_sequencer`

## Requirements
- R1: While reset is held and after its release, before any sync edge, `dac_code` is 0, `pt_valid` is 0 and `dac_clk` is 0.
- R2: Only the transition of `hsync_in` into its active level starts a line (active level is high when `hsync_pol` = 1, low when 0). The transition out of the active level has no effect on the sequence.
- R3: With the edge seen at master clock 0, `pt_idx` shows the first point and `pt_valid` rises after master clock `start_ofs`-1, and `dac_code` carries that point's value after master clock `start_ofs`, for `start_ofs` of 55 or more.
- R4: Each point index is presented for `hold_len`+1 master clocks, and `dac_code` follows it one master clock later, for `hold_len` of 12 or more.
- R5: Only points `first_pt` through `last_pt` (with `first_pt` <= `last_pt`) are visited: ascending when `fwd_scan` = 1, descending from `last_pt` when `fwd_scan` = 0. The direction is captured when the first point starts.
- R6: After the last point, `pt_valid` goes low, `pt_idx` keeps the last point, and `dac_code` holds its last value until the next run of points.
- R7: An active sync edge that arrives while points are being sequenced, or while waiting, restarts the start offset count from that edge.
- R8: When `corr_en` = 0 or `xfer_busy` = 1, `dac_code` equals `idle_code` from the next master clock on, while index sequencing continues unchanged.
- R9: `stby_mode` = 2'b10 is standby: `dac_oe` = 0, `dac_clk` = 0, `dac_code` loads `idle_code`, and the sequencer state, including `pt_idx` and `pt_valid`, is frozen until standby ends. Other values of `stby_mode` leave `dac_oe` = 1 and the block running.
- R10: With `div2_sel` = 1 every master clock spans two input clocks, so all programmed counts take twice as many input clocks.
- R11: `dac_clk` is a single master clock pulse issued `dclk_phase` master clocks after each new point value appears on `dac_code` (0 = in the same clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div2_sel | input | 1 | 1: master clock is half the input clock |
| hsync_in | input | 1 | Horizontal sync |
| hsync_pol | input | 1 | 1: sync active high, 0: active low |
| start_ofs | input | 8 | Master clocks from sync edge to first point value |
| hold_len | input | 8 | Point duration minus one, in master clocks |
| first_pt | input | 4 | Lowest point of the window |
| last_pt | input | 4 | Highest point of the window |
| fwd_scan | input | 1 | 1: ascending, 0: descending order |
| corr_en | input | 1 | 0: output the idle code |
| xfer_busy | input | 1 | 1: configuration transfer active, output the idle code |
| stby_mode | input | 2 | 2'b10 selects standby |
| idle_code | input | 6 | Code substituted for point values |
| dclk_phase | input | 3 | DAC strobe delay in master clocks |
| pt_data | input | 6 | Value of the point at `pt_idx`, from the interpolator |
| pt_idx | output | 4 | Current point index |
| pt_valid | output | 1 | Point sequencing active |
| dac_code | output | 6 | Registered code for the DAC |
| dac_oe | output | 1 | Output enable for DAC data and analog buffers |
| dac_clk | output | 1 | DAC strobe |

## Verification
The timing function is tried with a full 16-point ascending window at the shortest hold, a narrowed descending window under active-low sync with a longer hold and a delayed strobe, and a run cut short by a second sync edge. Together these separate off-by-one errors in the start offset from errors in the hold count, show whether the window and direction are decoded correctly, and show whether a trailing sync edge is wrongly taken as a start. Substitution runs give a nonzero idle code under both correction-off and transfer-busy, so a design that ignores either input gives wrong codes. A standby run cut in mid-line and a half-rate run measure freezing and clock-enable pacing in input clocks.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_e;

  localparam logic [1:0] STBY_ACTIVE = 2'b10;

endpackage

// File: rtl/hcp_clk_en.sv
module hcp_clk_en (
  input  logic clk,
  input  logic rst_n,
  input  logic div2_sel,
  output logic tick
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = div2_sel ? ~phase_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // full rate: every clock is a master clock; half rate: every second one
  assign tick = ~div2_sel | phase_q;

endmodule

// File: rtl/hcp_sync_edge.sv
module hcp_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sync_in,
  input  logic sync_pol,
  output logic edge_o
);

  logic act_lvl;
  logic lvl_q;

  assign act_lvl = sync_pol ? sync_in : ~sync_in;

  // reset value 1: a sync already active at reset release is not a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
    end else if (en) begin
      lvl_q <= act_lvl;
    end
  end

  assign edge_o = en & act_lvl & ~lvl_q;

endmodule

// File: rtl/hcp_point_ctrl.sv
module hcp_point_ctrl
  import hcp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_edge,
  input  logic [CNT_W-1:0] start_ofs,
  input  logic [CNT_W-1:0] hold_len,
  input  logic [IDX_W-1:0] first_pt,
  input  logic [IDX_W-1:0] last_pt,
  input  logic             fwd_scan,
  output logic [IDX_W-1:0] pt_idx,
  output logic             pt_valid,
  output logic             pt_load
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] ofs_q, ofs_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             dir_q, dir_d;
  logic [IDX_W-1:0] end_pt;

  assign end_pt = dir_q ? last_pt : first_pt;

  always_comb begin
    state_d = state_q;
    ofs_d   = ofs_q;
    hold_d  = hold_q;
    idx_d   = idx_q;
    dir_d   = dir_q;
    if (sync_edge) begin
      state_d = SEQ_WAIT;
      ofs_d   = CNT_ONE;
    end else begin
      unique case (state_q)
        SEQ_WAIT: begin
          if (ofs_q == start_ofs - CNT_ONE) begin
            state_d = SEQ_RUN;
            idx_d   = fwd_scan ? first_pt : last_pt;
            dir_d   = fwd_scan;
            hold_d  = '0;
          end else begin
            ofs_d = ofs_q + CNT_ONE;
          end
        end
        SEQ_RUN: begin
          if (hold_q == hold_len) begin
            hold_d = '0;
            if (idx_q == end_pt) begin
              state_d = SEQ_DONE;
            end else begin
              idx_d = dir_q ? idx_q + IDX_ONE : idx_q - IDX_ONE;
            end
          end else begin
            hold_d = hold_q + CNT_ONE;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ofs_q   <= '0;
      hold_q  <= '0;
      idx_q   <= '0;
      dir_q   <= 1'b1;
    end else if (en) begin
      state_q <= state_d;
      ofs_q   <= ofs_d;
      hold_q  <= hold_d;
      idx_q   <= idx_d;
      dir_q   <= dir_d;
    end
  end

  assign pt_idx   = idx_q;
  assign pt_valid = (state_q == SEQ_RUN);
  assign pt_load  = en & (state_q == SEQ_RUN) & (hold_q == '0);

endmodule

// File: rtl/hcp_dac_out.sv
module hcp_dac_out #(
  parameter int CODE_W = 6,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run_en,
  input  logic              pt_valid,
  input  logic              pt_load,
  input  logic [CODE_W-1:0] pt_data,
  input  logic              subst,
  input  logic [CODE_W-1:0] idle_code,
  input  logic [PH_W-1:0]   phase,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_clk
);

  localparam int STRB_N = 1 << PH_W;

  logic [CODE_W-1:0] code_q, code_d;
  logic [STRB_N-1:0] strb_q, strb_d;
  logic              strb_en;

  always_comb begin
    if (subst) begin
      code_d = idle_code;
    end else if (pt_valid) begin
      code_d = pt_data;
    end else begin
      code_d = code_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (tick) begin
      code_q <= code_d;
    end
  end

  // strobe delay line: stage k is high k master clocks after a new code
  assign strb_d[0] = pt_load;
  for (genvar k = 1; k < STRB_N; k++) begin : g_dly
    assign strb_d[k] = strb_q[k-1];
  end

  assign strb_en = tick & run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
    end else if (strb_en) begin
      strb_q <= strb_d;
    end
  end

  assign dac_code = code_q;
  assign dac_clk  = strb_q[phase] & run_en;

endmodule

// File: rtl/hcp_sequencer.sv
module hcp_sequencer
  import hcp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 8,
  parameter int CODE_W = 6,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div2_sel,
  input  logic              hsync_in,
  input  logic              hsync_pol,
  input  logic [CNT_W-1:0]  start_ofs,
  input  logic [CNT_W-1:0]  hold_len,
  input  logic [IDX_W-1:0]  first_pt,
  input  logic [IDX_W-1:0]  last_pt,
  input  logic              fwd_scan,
  input  logic              corr_en,
  input  logic              xfer_busy,
  input  logic [1:0]        stby_mode,
  input  logic [CODE_W-1:0] idle_code,
  input  logic [PH_W-1:0]   dclk_phase,
  input  logic [CODE_W-1:0] pt_data,
  output logic [IDX_W-1:0]  pt_idx,
  output logic              pt_valid,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_oe,
  output logic              dac_clk
);

  logic tick;
  logic standby;
  logic seq_en;
  logic subst;
  logic sync_edge;
  logic pt_load;

  assign standby = (stby_mode == STBY_ACTIVE);
  assign seq_en  = tick & ~standby;
  assign subst   = ~corr_en | xfer_busy | standby;
  assign dac_oe  = ~standby;

  hcp_clk_en u_clk_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .div2_sel (div2_sel),
    .tick     (tick)
  );

  hcp_sync_edge u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (seq_en),
    .sync_in  (hsync_in),
    .sync_pol (hsync_pol),
    .edge_o   (sync_edge)
  );

  hcp_point_ctrl #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (seq_en),
    .sync_edge (sync_edge),
    .start_ofs (start_ofs),
    .hold_len  (hold_len),
    .first_pt  (first_pt),
    .last_pt   (last_pt),
    .fwd_scan  (fwd_scan),
    .pt_idx    (pt_idx),
    .pt_valid  (pt_valid),
    .pt_load   (pt_load)
  );

  hcp_dac_out #(
    .CODE_W (CODE_W),
    .PH_W   (PH_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run_en    (~standby),
    .pt_valid  (pt_valid),
    .pt_load   (pt_load),
    .pt_data   (pt_data),
    .subst     (subst),
    .idle_code (idle_code),
    .phase     (dclk_phase),
    .dac_code  (dac_code),
    .dac_clk   (dac_clk)
  );

endmodule

// File: rtl/hcp_sequencer_chk.sv
module hcp_sequencer_chk #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              div2_sel,
  input logic              corr_en,
  input logic              xfer_busy,
  input logic [1:0]        stby_mode,
  input logic [CODE_W-1:0] idle_code,
  input logic [IDX_W-1:0]  first_pt,
  input logic [IDX_W-1:0]  last_pt,
  input logic [IDX_W-1:0]  pt_idx,
  input logic              pt_valid,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_clk
);

  // R5
  idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |-> (pt_idx >= first_pt && pt_idx <= last_pt));

  // R8
  idle_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !div2_sel && $past(!div2_sel) && $past(!corr_en || xfer_busy)
     && $past(stby_mode) != 2'b10 && $stable(idle_code)) |-> (dac_code == idle_code));

  // R9
  stby_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && stby_mode == 2'b10 && $past(stby_mode) == 2'b10)
      |-> ($stable(pt_idx) && $stable(pt_valid)));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!pt_valid) && $past(corr_en) && $past(!xfer_busy)
     && $past(stby_mode) != 2'b10) |-> $stable(dac_code));

  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(dac_clk) && !div2_sel && $past(!div2_sel)) |=> !dac_clk);

endmodule

bind hcp_sequencer hcp_sequencer_chk #(
  .IDX_W  (IDX_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div2_sel  (div2_sel),
  .corr_en   (corr_en),
  .xfer_busy (xfer_busy),
  .stby_mode (stby_mode),
  .idle_code (idle_code),
  .first_pt  (first_pt),
  .last_pt   (last_pt),
  .pt_idx    (pt_idx),
  .pt_valid  (pt_valid),
  .dac_code  (dac_code),
  .dac_clk   (dac_clk)
);

// File: tb/tb_hcp_sequencer.sv
module tb_hcp_sequencer;

  logic       clk;
  logic       rst_n;
  logic       div2_sel;
  logic       hsync_in;
  logic       hsync_pol;
  logic [7:0] start_ofs;
  logic [7:0] hold_len;
  logic [3:0] first_pt;
  logic [3:0] last_pt;
  logic       fwd_scan;
  logic       corr_en;
  logic       xfer_busy;
  logic [1:0] stby_mode;
  logic [5:0] idle_code;
  logic [2:0] dclk_phase;
  logic [5:0] pt_data;
  logic [3:0] pt_idx;
  logic       pt_valid;
  logic [5:0] dac_code;
  logic       dac_oe;
  logic       dac_clk;

  int n_chk;
  int n_fail;
  bit finished;
  logic [5:0] code_prev;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // interpolator model: each point has a distinct value
  assign pt_data = 6'(({2'b00, pt_idx} * 6'd3) + 6'd5);

  hcp_sequencer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .div2_sel   (div2_sel),
    .hsync_in   (hsync_in),
    .hsync_pol  (hsync_pol),
    .start_ofs  (start_ofs),
    .hold_len   (hold_len),
    .first_pt   (first_pt),
    .last_pt    (last_pt),
    .fwd_scan   (fwd_scan),
    .corr_en    (corr_en),
    .xfer_busy  (xfer_busy),
    .stby_mode  (stby_mode),
    .idle_code  (idle_code),
    .dclk_phase (dclk_phase),
    .pt_data    (pt_data),
    .pt_idx     (pt_idx),
    .pt_valid   (pt_valid),
    .dac_code   (dac_code),
    .dac_oe     (dac_oe),
    .dac_clk    (dac_clk)
  );

  function automatic logic [5:0] code_of(input int idx);
    return 6'((idx * 3) + 5);
  endfunction

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Starts a line at the current negedge and checks every master clock.
  // t counts clocks after the edge-detecting clock edge (t = 0).
  task automatic run_line(input int hp, input int hint, input int first, input int last,
                          input bit fwd, input int phase, input int stop_t,
                          input bit subst, input string tag1, input string tag2);
    int period;
    int npts;
    int k;
    int idx;
    int rel;
    logic [5:0] e_code;
    bit e_valid;
    bit e_clk;
    period     = hint + 1;
    npts       = last - first + 1;
    start_ofs  = 8'(hp);
    hold_len   = 8'(hint);
    first_pt   = 4'(first);
    last_pt    = 4'(last);
    fwd_scan   = fwd;
    dclk_phase = 3'(phase);
    hsync_in   = hsync_pol;
    e_code     = code_prev;
    for (int t = 0; t < stop_t; t++) begin
      @(negedge clk);
      if (t == 8) hsync_in = ~hsync_pol; // R2: trailing edge must not restart
      if (subst) begin
        e_code = idle_code;
      end else if (t >= hp) begin
        k = (t - hp) / period;
        if (k >= npts) k = npts - 1;
        idx = fwd ? first + k : last - k;
        e_code = code_of(idx);
      end else begin
        e_code = code_prev;
      end
      e_valid = (t >= hp - 1) && (t < hp - 1 + npts * period);
      rel = t - hp - phase;
      e_clk = (rel >= 0) && (rel % period == 0) && (rel / period < npts);
      chk_eq((t == hp) ? tag1 : ((t > hp + npts * period) ? "R6" : tag2),
             $sformatf("dac_code t=%0d", t), int'(dac_code), int'(e_code));
      chk_eq((t >= hp - 1 + npts * period) ? "R6" : "R3",
             $sformatf("pt_valid t=%0d", t), int'(pt_valid), int'(e_valid));
      chk_eq("R11", $sformatf("dac_clk t=%0d", t), int'(dac_clk), int'(e_clk));
    end
    code_prev = e_code;
  endtask

  task automatic t_reset();
    // R1
    chk_eq("R1", "dac_code in reset", int'(dac_code), 0);
    chk_eq("R1", "pt_valid in reset", int'(pt_valid), 0);
    chk_eq("R1", "dac_clk in reset", int'(dac_clk), 0);
    chk_eq("R1", "dac_oe in reset", int'(dac_oe), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1", "dac_code after release", int'(dac_code), 0);
    chk_eq("R1", "pt_valid after release", int'(pt_valid), 0);
  endtask

  task automatic t_forward();
    run_line(60, 12, 0, 15, 1'b1, 0, 60 + 16 * 13 + 10, 1'b0, "R3", "R4");
  endtask

  task automatic t_reverse_lowpol();
    hsync_pol = 1'b0;
    hsync_in  = 1'b1;
    repeat (2) @(negedge clk);
    run_line(55, 24, 2, 13, 1'b0, 2, 55 + 12 * 25 + 10, 1'b0, "R2", "R5");
    hsync_pol = 1'b1;
    hsync_in  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_restart();
    run_line(58, 13, 1, 9, 1'b1, 1, 58 + 2 * 14 + 5, 1'b0, "R3", "R4");
    run_line(58, 13, 1, 9, 1'b1, 1, 58 + 9 * 14 + 10, 1'b0, "R7", "R7");
  endtask

  task automatic t_subst();
    corr_en   = 1'b0;
    idle_code = 6'h2A;
    run_line(56, 12, 3, 6, 1'b1, 0, 56 + 4 * 13 + 10, 1'b1, "R8", "R8");
    corr_en   = 1'b1;
    xfer_busy = 1'b1;
    idle_code = 6'h11;
    run_line(56, 12, 3, 6, 1'b1, 0, 56 + 4 * 13 + 10, 1'b1, "R8", "R8");
    xfer_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R6", "code held after transfer ends", int'(dac_code), int'(6'h11));
    code_prev = 6'h11;
  endtask

  task automatic t_standby();
    logic [3:0] saved;
    int cnt;
    stby_mode = 2'b01;
    @(negedge clk);
    chk_eq("R9", "dac_oe with mode 01", int'(dac_oe), 1);
    stby_mode = 2'b11;
    @(negedge clk);
    chk_eq("R9", "dac_oe with mode 11", int'(dac_oe), 1);
    stby_mode = 2'b00;
    run_line(57, 15, 4, 7, 1'b1, 1, 76, 1'b0, "R3", "R4");
    stby_mode = 2'b10;
    saved = pt_idx;
    @(negedge clk);
    chk_eq("R9", "dac_oe in standby", int'(dac_oe), 0);
    chk_eq("R9", "dac_code in standby", int'(dac_code), int'(idle_code));
    repeat (20) begin
      @(negedge clk);
      if (dac_clk) chk_eq("R9", "dac_clk in standby", 1, 0);
    end
    chk_eq("R9", "pt_idx frozen", int'(pt_idx), int'(saved));
    chk_eq("R9", "pt_valid frozen", int'(pt_valid), 1);
    stby_mode = 2'b00;
    cnt = 0;
    while (cnt < 500) begin
      @(negedge clk);
      cnt++;
      if (!pt_valid) break;
    end
    chk_eq("R9", "clocks to finish after standby", cnt, (56 + 4 * 16) - 76 + 1);
    chk_eq("R6", "final code after standby", int'(dac_code), int'(code_of(7)));
    chk_eq("R6", "final index", int'(pt_idx), 7);
    code_prev = code_of(7);
  endtask

  task automatic t_half_rate();
    int cnt;
    logic [3:0] prev;
    div2_sel   = 1'b1;
    start_ofs  = 8'd56;
    hold_len   = 8'd12;
    first_pt   = 4'd0;
    last_pt    = 4'd3;
    fwd_scan   = 1'b1;
    dclk_phase = 3'd0;
    hsync_in   = 1'b1;
    cnt = 0;
    while (cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (cnt == 8) hsync_in = 1'b0;
      if (pt_valid) break;
    end
    n_chk++;
    if (cnt < 2 * 55 + 1 || cnt > 2 * 55 + 2) begin
      n_fail++;
      $display("FAIL R10 start delay: actual %0d expected %0d or %0d", cnt, 111, 112);
    end
    for (int j = 0; j < 2; j++) begin
      prev = pt_idx;
      cnt = 0;
      while (cnt < 500) begin
        @(negedge clk);
        cnt++;
        if (pt_idx != prev) break;
      end
      chk_eq("R10", $sformatf("half-rate point %0d length", j), cnt, 26);
    end
    cnt = 0;
    while (cnt < 500 && pt_valid) begin
      @(negedge clk);
      cnt++;
    end
    repeat (3) @(negedge clk);
    chk_eq("R10", "half-rate last code", int'(dac_code), int'(code_of(3)));
    div2_sel  = 1'b0;
    code_prev = code_of(3);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_chk      = 0;
    n_fail     = 0;
    finished   = 1'b0;
    code_prev  = 6'd0;
    rst_n      = 1'b0;
    div2_sel   = 1'b0;
    hsync_in   = 1'b0;
    hsync_pol  = 1'b1;
    start_ofs  = 8'd60;
    hold_len   = 8'd12;
    first_pt   = 4'd0;
    last_pt    = 4'd15;
    fwd_scan   = 1'b1;
    corr_en    = 1'b1;
    xfer_busy  = 1'b0;
    stby_mode  = 2'b00;
    idle_code  = 6'h00;
    dclk_phase = 3'd0;
    repeat (3) @(negedge clk);
    t_reset();
    t_forward();
    t_reverse_lowpol();
    t_restart();
    t_subst();
    t_standby();
    t_half_rate();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule